// File: doc/BRIEF.md
# Digit-Serial Montgomery Multiplier (17-bit digits)

This block computes the Montgomery product S = X·Y·2^(-17d) mod M for operands of d digits, each digit 17 bits wide. The operands live in an internal digit store split into four regions: multiplicand X, multiplier Y, modulus M and result S. Software or a surrounding controller fills X, Y and M through a plain write port. It then presents the digit count d and the constant −M⁻¹ mod 2^17 and pulses `start`. After a fixed number of cycles, `done` pulses for one cycle and the result can be read back from the S region. The inverse constant is precomputed outside the block.

For every multiplier digit Y_i, the block spends two cycles forming the quotient digit q from X_0, Y_i, the lowest running-sum digit and the inverse constant. It then sweeps j = 0 … d in d+1 cycles, one digit per cycle. Two 17×17 multipliers, two 17-bit product carries and two 1-bit addition carries keep the per-cycle logic short. Digits above index d−1 of X and M are treated as zero. The running sum is treated as zero during the first pass. The digit produced at j = 0 is dropped, and each later digit is written back one place lower in S. There is no final subtraction. The caller must keep M below 2^(17d−3), so the result always stays below 2M and fits in d digits.

The controller has five states. IDLE waits for start with a non-zero count. QPROD latches the low digit of X_0·Y_i + S_0. QMUL multiplies that by the inverse constant to give q and clears the carries. SWEEP steps j up to d. FIN raises done. The transitions are:
- IDLE→QPROD on start.
- QPROD→QMUL and QMUL→SWEEP unconditionally.
- SWEEP→SWEEP while j < d.
- SWEEP→QPROD at j = d when more Y digits remain.
- SWEEP→FIN at j = d on the last Y digit.
- FIN→IDLE unconditionally.

Top module: `mont17_mul`

## Requirements
- R1: With M odd, M < 2^(17d−3), and X, Y < 2M, the d-digit value left in the S region after done satisfies S·2^(17d) ≡ X·Y (mod M) and S < 2M.
- R2: done is high for exactly one cycle. It is first seen high after the edge that lies d·(d+3) edges after the edge that sampled start.
- R3: Address bits [8:7] select the region (0 = X, 1 = Y, 2 = M, 3 = S). Bits [6:0] give the digit index, with the least significant digit at index 0. mem_rdata is a combinational read of the addressed digit.
- R4: While a computation runs, mem_we has no effect on any region.
- R5: A start pulse during a running computation is ignored: the latency and the result are unchanged.
- R6: Within each pass, the digit formed at j = 0 is zero and is discarded. No carry leaves the digit at j = d.
- R7: A zero multiplier gives an all-zero result.
- R8: Any digit count from 1 to MAX_DIGITS is accepted and sampled at start. A start with a count of zero is ignored.
- R9: During and after reset, done is low and the controller is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiplication (sampled in IDLE) |
| n_digits | input | 8 | Digit count d, 1 to MAX_DIGITS |
| neg_minv | input | 17 | −M⁻¹ mod 2^17 |
| mem_we | input | 1 | Write enable for the digit store (honoured only in IDLE) |
| mem_addr | input | 9 | Region and digit index |
| mem_wdata | input | 17 | Digit to write |
| mem_rdata | output | 17 | Digit at mem_addr |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each digit of Y costs d+3 cycles, so done is due d·(d+3) edges after the start edge. The bench counts edges from the one that samples start and requires done at exactly that count. It samples on the falling edge between rising edges, and checks that done has dropped one edge later. The result is read only after done. It is judged against a wide-integer congruence and the bound 2M, not against a replica of the datapath. The store-protection check reads X back after the run ends. The restart check compares latency and result with an undisturbed run of the same vector.

// File: rtl/mont17_pkg.sv
package mont17_pkg;
    localparam int DW = 17;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QPROD,
        ST_QMUL,
        ST_SWEEP,
        ST_FIN
    } mstate_t;
endpackage

// File: rtl/mont17_bank.sv
module mont17_bank #(
    parameter int DW    = 17,
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ext_raddr,
    output logic [DW-1:0] ext_rdata,
    input  logic [AW-1:0] int_raddr,
    output logic [DW-1:0] int_rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign ext_rdata = mem[ext_raddr];
    assign int_rdata = mem[int_raddr];
endmodule

// File: rtl/mont17_ctrl.sv
module mont17_ctrl
    import mont17_pkg::*;
#(
    parameter int CW = 8,
    parameter int LW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] n_digits,
    output logic [LW-1:0] i_addr,
    output logic [LW-1:0] j_addr,
    output logic          first,
    output logic          busy,
    output logic          t_load,
    output logic          q_load,
    output logic          clr,
    output logic          step_en,
    output logic          j_zero,
    output logic          j_last,
    output logic          s_we,
    output logic          done
);
    mstate_t state, nstate;
    logic [CW-1:0] d_reg, i_cnt, j_cnt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (start && n_digits != '0) nstate = ST_QPROD;
            ST_QPROD: nstate = ST_QMUL;
            ST_QMUL:  nstate = ST_SWEEP;
            ST_SWEEP: if (j_cnt == d_reg)
                          nstate = (i_cnt == d_reg - CW'(1)) ? ST_FIN : ST_QPROD;
            ST_FIN:   nstate = ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    // loop counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_reg <= '0;
            i_cnt <= '0;
            j_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start && n_digits != '0) begin
                    d_reg <= n_digits;
                    i_cnt <= '0;
                    j_cnt <= '0;
                end
                ST_SWEEP: if (j_cnt == d_reg) begin
                    j_cnt <= '0;
                    i_cnt <= i_cnt + CW'(1);
                end else begin
                    j_cnt <= j_cnt + CW'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        t_load  = (state == ST_QPROD);
        q_load  = (state == ST_QMUL);
        clr     = (state == ST_QMUL);
        step_en = (state == ST_SWEEP);
        done    = (state == ST_FIN);
        j_zero  = (j_cnt == '0);
        j_last  = (j_cnt == d_reg);
        s_we    = (state == ST_SWEEP) && (j_cnt != '0);
        first   = (i_cnt == '0);
        i_addr  = i_cnt[LW-1:0];
        j_addr  = j_cnt[LW-1:0];
    end

    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> (j_cnt <= d_reg && i_cnt < d_reg));
    a_r5_count_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(d_reg));
    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/mont17_step.sv
module mont17_step
    import mont17_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] x_j,
    input  logic [DW-1:0] y_i,
    input  logic [DW-1:0] m_j,
    input  logic [DW-1:0] s_ij,
    input  logic [DW-1:0] neg_minv,
    input  logic          t_load,
    input  logic          q_load,
    input  logic          clr,
    input  logic          step_en,
    input  logic          j_zero,
    input  logic          j_last,
    output logic [DW-1:0] s_digit
);
    logic [2*DW-1:0] prod_a, prod_b, sum_a, sum_b;
    logic [DW-1:0]   mul_l, mul_r, t_r, q_r, ca, cb;
    logic [DW:0]     sum_g, sum_s;
    logic            cg, cs;

    always_comb begin
        mul_l  = q_load ? t_r : q_r;
        mul_r  = q_load ? neg_minv : m_j;
        prod_a = (2*DW)'(x_j) * (2*DW)'(y_i);
        prod_b = (2*DW)'(mul_l) * (2*DW)'(mul_r);
        sum_a  = prod_a + (2*DW)'(ca);
        sum_b  = prod_b + (2*DW)'(cb);
        sum_g  = {1'b0, sum_a[DW-1:0]} + {1'b0, sum_b[DW-1:0]} + (DW+1)'(cg);
        sum_s  = {1'b0, sum_g[DW-1:0]} + {1'b0, s_ij} + (DW+1)'(cs);
        s_digit = sum_s[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_r <= '0;
            q_r <= '0;
            ca  <= '0;
            cb  <= '0;
            cg  <= 1'b0;
            cs  <= 1'b0;
        end else begin
            if (t_load) t_r <= prod_a[DW-1:0] + s_ij;
            if (q_load) q_r <= prod_b[DW-1:0];
            if (clr) begin
                ca <= '0;
                cb <= '0;
                cg <= 1'b0;
                cs <= 1'b0;
            end else if (step_en) begin
                ca <= sum_a[2*DW-1:DW];
                cb <= sum_b[2*DW-1:DW];
                cg <= sum_g[DW];
                cs <= sum_s[DW];
            end
        end
    end

    // the quotient digit must cancel the lowest digit of every pass
    a_r6_low_digit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && j_zero) |-> (sum_s[DW-1:0] == '0));
    // redundancy keeps the top step free of carries
    a_r6_no_top_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && j_last) |-> (!sum_s[DW] && !sum_g[DW] && sum_a[2*DW-1:DW] == '0));
endmodule

// File: rtl/mont17_mul.sv
module mont17_mul
    import mont17_pkg::*;
#(
    parameter int MAX_DIGITS = 128,
    parameter int LW = $clog2(MAX_DIGITS),
    parameter int CW = $clog2(MAX_DIGITS + 1),
    parameter int AW = LW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] n_digits,
    input  logic [DW-1:0] neg_minv,
    input  logic          mem_we,
    input  logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] mem_rdata,
    output logic          done
);
    localparam int NB = 4;

    logic [LW-1:0] i_addr, j_addr, s_waddr;
    logic first, busy, t_load, q_load, clr, step_en, j_zero, j_last, s_we;
    logic [DW-1:0] s_digit, x_j, y_i, m_j, s_ij;
    logic [1:0]    sel;
    logic [DW-1:0] ext_rd [NB];
    logic [DW-1:0] int_rd [NB];
    logic [NB-1:0] bank_we;

    assign sel     = mem_addr[AW-1:LW];
    assign s_waddr = j_addr - LW'(1);

    mont17_ctrl #(.CW(CW), .LW(LW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .n_digits(n_digits),
        .i_addr(i_addr), .j_addr(j_addr), .first(first), .busy(busy),
        .t_load(t_load), .q_load(q_load), .clr(clr), .step_en(step_en),
        .j_zero(j_zero), .j_last(j_last), .s_we(s_we), .done(done)
    );

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank
            logic [LW-1:0] waddr_b, raddr_b;
            logic [DW-1:0] wdata_b;
            assign bank_we[b] = busy ? ((b == NB - 1) && s_we)
                                     : (mem_we && sel == 2'(b));
            assign waddr_b = busy ? s_waddr : mem_addr[LW-1:0];
            assign wdata_b = busy ? s_digit : mem_wdata;
            assign raddr_b = (b == 1) ? i_addr : j_addr;
            mont17_bank #(.DW(DW), .DEPTH(MAX_DIGITS), .AW(LW)) u_bank (
                .clk(clk), .we(bank_we[b]), .waddr(waddr_b), .wdata(wdata_b),
                .ext_raddr(mem_addr[LW-1:0]), .ext_rdata(ext_rd[b]),
                .int_raddr(raddr_b), .int_rdata(int_rd[b])
            );
        end
    endgenerate

    always_comb begin
        mem_rdata = ext_rd[sel];
        x_j  = j_last ? '0 : int_rd[0];
        y_i  = int_rd[1];
        m_j  = j_last ? '0 : int_rd[2];
        s_ij = (first || j_last) ? '0 : int_rd[3];
    end

    mont17_step u_step (
        .clk(clk), .rst_n(rst_n), .x_j(x_j), .y_i(y_i), .m_j(m_j), .s_ij(s_ij),
        .neg_minv(neg_minv), .t_load(t_load), .q_load(q_load), .clr(clr),
        .step_en(step_en), .j_zero(j_zero), .j_last(j_last), .s_digit(s_digit)
    );

    a_r4_store_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bank_we[2:0] == 3'b000));
    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !done);
endmodule

// File: tb/test_mont17_mul.sv
module test_mont17_mul;
    localparam int W  = 320;
    localparam int NV = 7;
    localparam int VD [NV] = '{1, 1, 2, 3, 4, 4, 8};
    localparam logic [W-1:0] VM [NV] = '{
        W'(13), W'(16381), W'(2147483647),
        (W'(1) << 48) - W'(59), (W'(1) << 65) - W'(49),
        (W'(1) << 65) - W'(49), (W'(1) << 133) - W'(1)};
    localparam logic [W-1:0] VX [NV] = '{
        W'(5), W'(16380), W'(123456789),
        (W'(1) << 48) - W'(60), (W'(1) << 64) + W'(12345),
        (W'(1) << 65) - W'(50), (W'(1) << 132) + W'(7)};
    localparam logic [W-1:0] VY [NV] = '{
        W'(7), W'(16380), W'(987654321),
        (W'(1) << 48) - W'(60), W'(0),
        W'(3), (W'(1) << 100) + W'(99)};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] n_digits = '0;
    logic [16:0] neg_minv = '0;
    logic mem_we = 1'b0;
    logic [8:0] mem_addr = '0;
    logic [16:0] mem_wdata = '0;
    logic [16:0] mem_rdata;
    logic done;
    int n_chk = 0;
    int n_fail = 0;

    always #5ns clk = ~clk;

    mont17_mul i_mont17_mul (
        .clk(clk), .rst_n(rst_n), .start(start), .n_digits(n_digits),
        .neg_minv(neg_minv), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [16:0] neg_inv(input logic [16:0] m0);
        logic [33:0] inv, t;
        inv = 34'(m0);
        for (int k = 0; k < 5; k++) begin
            t   = (inv * 34'(m0)) & 34'h1FFFF;
            inv = (inv * ((34'd2 - t) & 34'h1FFFF)) & 34'h1FFFF;
        end
        return 17'd0 - inv[16:0];
    endfunction

    task automatic wr(input int region, input int idx, input logic [16:0] v);
        @(negedge clk);
        mem_we = 1'b1; mem_addr = {2'(region), 7'(idx)}; mem_wdata = v;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic rd(input int region, input int idx, output logic [16:0] v);
        mem_addr = {2'(region), 7'(idx)};
        #1ns;
        v = mem_rdata;
    endtask

    task automatic load(input int region, input logic [W-1:0] val, input int d);
        for (int k = 0; k < d; k++) wr(region, k, val[17*k +: 17]);
    endtask

    task automatic fetch_s(input int d, output logic [W-1:0] val);
        logic [16:0] dg;
        val = '0;
        for (int k = 0; k < d; k++) begin
            rd(3, k, dg);
            val[17*k +: 17] = dg;
        end
    endtask

    // runs one multiplication; poke drives start and a write to X[0] mid-run
    task automatic run(input int d, input bit poke, output int cyc, output bit ok);
        @(negedge clk);
        start = 1'b1; n_digits = 8'(d);
        cyc = 0; ok = 1'b0;
        while (!ok && cyc < 20000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start = 1'b0; mem_we = 1'b0;
            if (done) ok = 1'b1;
            else if (poke && cyc == 3) begin
                start = 1'b1; mem_we = 1'b1;
                mem_addr = {2'd0, 7'd0}; mem_wdata = 17'h1ABCD;
            end
        end
    endtask

    task automatic judge(input int v, input string tag, input int cyc, input bit ok);
        logic [W-1:0] s, lhs, rhs;
        int d;
        d = VD[v];
        chk(ok, "R2", {tag, " done seen"}, W'(ok), W'(1));
        chk(cyc == d * (d + 3) + 1, "R2", {tag, " latency"}, W'(cyc), W'(d * (d + 3) + 1));
        @(posedge clk); @(negedge clk);
        chk(done == 1'b0, "R2", {tag, " single pulse"}, W'(done), W'(0));
        fetch_s(d, s);
        lhs = (s << (17 * d)) % VM[v];
        rhs = (VX[v] * VY[v]) % VM[v];
        chk(lhs == rhs, "R1", {tag, " congruence"}, lhs, rhs);
        chk(s < (VM[v] << 1), "R1", {tag, " below 2M"}, s, VM[v] << 1);
        if (VY[v] == '0) chk(s == '0, "R7", {tag, " zero multiplier"}, s, W'(0));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        int cyc, cyc_ref;
        bit ok;
        logic [16:0] dg;
        logic [W-1:0] s_ref, s_now;

        // R9: reset state
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R9", "done in reset", W'(done), W'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R9", "done after reset", W'(done), W'(0));

        // R3: region map readback
        wr(2, 5, 17'h15555);
        wr(1, 5, 17'h0AAAA);
        rd(2, 5, dg);
        chk(dg == 17'h15555, "R3", "M region readback", W'(dg), W'(17'h15555));
        rd(1, 5, dg);
        chk(dg == 17'h0AAAA, "R3", "Y region readback", W'(dg), W'(17'h0AAAA));

        // vector table
        for (int v = 0; v < NV; v++) begin
            load(0, VX[v], VD[v]);
            load(1, VY[v], VD[v]);
            load(2, VM[v], VD[v]);
            neg_minv = neg_inv(VM[v][16:0]);
            run(VD[v], 1'b0, cyc, ok);
            judge(v, $sformatf("vec%0d", v), cyc, ok);
        end

        // R4/R5: restart and write during a run are ignored (vector 3 again)
        load(0, VX[3], VD[3]);
        load(1, VY[3], VD[3]);
        load(2, VM[3], VD[3]);
        neg_minv = neg_inv(VM[3][16:0]);
        run(VD[3], 1'b0, cyc_ref, ok);
        @(negedge clk);
        fetch_s(VD[3], s_ref);
        run(VD[3], 1'b1, cyc, ok);
        chk(cyc == cyc_ref, "R5", "latency with restart", W'(cyc), W'(cyc_ref));
        @(negedge clk);
        fetch_s(VD[3], s_now);
        chk(s_now == s_ref, "R5", "result with restart", s_now, s_ref);
        rd(0, 0, dg);
        chk(dg == VX[3][16:0], "R4", "X digit after busy write", W'(dg), W'(VX[3][16:0]));

        // R8: zero count is ignored
        @(negedge clk);
        start = 1'b1; n_digits = 8'd0;
        @(negedge clk);
        start = 1'b0;
        ok = 1'b0;
        repeat (12) begin
            @(negedge clk);
            if (done) ok = 1'b1;
        end
        chk(ok == 1'b0, "R8", "zero count start", W'(ok), W'(0));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule